// File: doc/BRIEF.md
# Microcontroller Bus and Port-2 Pin Restoration

This block sits between a microcontroller core with no program ROM and the pin boundary of a "virtual" part. When the core fetches code from external memory, the fetch uses up the multiplexed data bus and the low nibble of port 2. The block gives those twelve pins back to the user's system.

It has four jobs:

- It latches the low address byte while ALE is high.
- It holds bus-write data in a register that loads when WR returns high.
- It captures the port-2 low-nibble output value when ALE rises. Each of those four pins can be set as an input or an output on its own. Input pins are gated off while the program strobe is active.
- It decides whether a program fetch goes to on-board memory or off-board through an external program strobe. An off-board fetch happens when the fetch targets bank 1 or when the external-access pin is high.

All strobes are sampled in one system clock domain. Edges are found by comparing each strobe with its value from the previous cycle.

Top module: `ioRestore`

## Requirements
- R1: While `aleIn` is 1, `addrLow` follows `coreBusOut` in the same cycle. While `aleIn` is 0, `addrLow` holds the bus value from the last clock edge at which `aleIn` was 1.
- R2: At the first clock edge where `wrN` is sampled 1 after being 0, `dbPinOut` takes the `coreBusOut` value sampled at the last edge where `wrN` was 0.
- R3: With no such WR rise (for example a read-modify-write bus operation that gives no WR strobe, or bus activity during reads), `dbPinOut` does not change.
- R4: While `rdN` is 0, `dbPinOe` is 0 and `coreBusIn` equals `dbPinIn`. While `rdN` is 1, `dbPinOe` is 1 and `coreBusIn` is all ones.
- R5: At a clock edge where `aleIn` is sampled 1 after being 0, `p2PinOut` takes `coreP2Out`. At every other edge it holds its value.
- R6: `p2PinOe[i]` equals `dirCfg[i]` for each of the four pins, where 1 means output and 0 means input. Any mix of the two is allowed.
- R7: `coreP2In[i]` equals `p2PinIn[i]` when `psenN` is 1 and `dirCfg[i]` is 0. Otherwise it is 1, which means released.
- R8: `extPsenN` is 0 exactly when `psenN` is 0 and either `pcHigh` is 1 (bank 1) or `eaPin` is 1.
- R9: `romEnN` is 0 exactly when `psenN` is 0, `pcHigh` is 0 and `eaPin` is 0. `romEnN` and `extPsenN` are never 0 at the same time.
- R10: After reset, `dbPinOut` is all ones and `p2PinOut` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreBusOut | input | BUS_W | Value the core drives on its multiplexed bus |
| coreBusIn | output | BUS_W | Value returned to the core bus during reads |
| aleIn | input | 1 | Address latch enable from the core |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| psenN | input | 1 | Program strobe from the core, active low |
| pcHigh | input | 1 | Program-counter bank bit |
| coreP2Out | input | NIB_W | Core drive on port-2 low nibble |
| coreP2In | output | NIB_W | Gated input values toward the core port-2 nibble |
| dirCfg | input | NIB_W | Per-pin direction, 1 = output |
| dbPinIn | input | BUS_W | Virtual data-bus pin inputs |
| dbPinOut | output | BUS_W | Virtual data-bus latched output |
| dbPinOe | output | 1 | Virtual data-bus output enable |
| p2PinIn | input | NIB_W | Virtual port-2 low pin inputs |
| p2PinOut | output | NIB_W | Virtual port-2 low latched output |
| p2PinOe | output | NIB_W | Virtual port-2 low per-pin output enable |
| eaPin | input | 1 | Virtual external-access input |
| addrLow | output | BUS_W | Latched low address byte |
| romEnN | output | 1 | On-board program memory enable, active low |
| extPsenN | output | 1 | Virtual external program strobe, active low |

## Verification
The bench uses the default widths: an 8-bit bus and a 4-bit nibble. At these widths the port-2 input gating can be swept exhaustively, covering every direction setting against every pin pattern in both program-strobe states. All eight combinations of program strobe, bank bit and external access are also covered. The nibble capture is tried with all sixteen values. Bus writes use several byte patterns, with the bus changed in the same cycle WR rises. Strobe-free bus activity then shows that the trailing-edge register holds.

// File: rtl/ioRestorePkg.sv
package ioRestorePkg;
  typedef struct packed {
    logic wrRise;   // WR returned high this cycle
    logic wrLow;    // WR currently low
    logic aleRise;  // ALE went high this cycle
    logic aleOpen;  // ALE currently high
  } ctlStrobes_t;
endpackage

// File: rtl/ioRestoreControl.sv
module ioRestoreControl
  import ioRestorePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aleIn,
  input  logic        wrN,
  input  logic        psenN,
  input  logic        pcHigh,
  input  logic        eaPin,
  output ctlStrobes_t strobes,
  output logic        romEnN,
  output logic        extPsenN
);
  logic alePrev;
  logic wrPrev;
  logic offBoard;
  logic fetchActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alePrev <= 1'b0;
      wrPrev  <= 1'b1;
    end else begin
      alePrev <= aleIn;
      wrPrev  <= wrN;
    end
  end

  always_comb begin
    strobes.wrRise  = wrN & ~wrPrev;
    strobes.wrLow   = ~wrN;
    strobes.aleRise = aleIn & ~alePrev;
    strobes.aleOpen = aleIn;
  end

  // Program-memory select: bank 1 or external access sends the fetch off-board
  assign fetchActive = ~psenN;
  assign offBoard    = pcHigh | eaPin;
  assign extPsenN    = ~(fetchActive & offBoard);
  assign romEnN      = ~(fetchActive & ~offBoard);
endmodule

// File: rtl/ioRestoreDatapath.sv
module ioRestoreDatapath
  import ioRestorePkg::*;
#(
  parameter int BUS_W = 8,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             rdN,
  input  logic             psenN,
  input  logic [BUS_W-1:0] coreBusOut,
  output logic [BUS_W-1:0] coreBusIn,
  input  logic [NIB_W-1:0] coreP2Out,
  output logic [NIB_W-1:0] coreP2In,
  input  logic [NIB_W-1:0] dirCfg,
  input  logic [BUS_W-1:0] dbPinIn,
  output logic [BUS_W-1:0] dbPinOut,
  output logic             dbPinOe,
  input  logic [NIB_W-1:0] p2PinIn,
  output logic [NIB_W-1:0] p2PinOut,
  output logic [NIB_W-1:0] p2PinOe,
  output logic [BUS_W-1:0] addrLow
);
  localparam logic [BUS_W-1:0] BUS_IDLE = {BUS_W{1'b1}};
  localparam logic [NIB_W-1:0] NIB_IDLE = {NIB_W{1'b1}};

  logic [BUS_W-1:0] addrHeld;
  logic [BUS_W-1:0] busHold;
  logic [BUS_W-1:0] dbReg;
  logic [NIB_W-1:0] p2Reg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHeld <= '0;
      busHold  <= BUS_IDLE;
      dbReg    <= BUS_IDLE;
      p2Reg    <= NIB_IDLE;
    end else begin
      if (strobes.aleOpen) addrHeld <= coreBusOut;
      if (strobes.wrLow)   busHold  <= coreBusOut;
      if (strobes.wrRise)  dbReg    <= busHold;
      if (strobes.aleRise) p2Reg    <= coreP2Out;
    end
  end

  // Transparent address path while ALE is open
  assign addrLow = strobes.aleOpen ? coreBusOut : addrHeld;

  // Bus direction: inward only during a read strobe
  assign dbPinOe   = rdN;
  assign dbPinOut  = dbReg;
  assign coreBusIn = rdN ? BUS_IDLE : dbPinIn;

  assign p2PinOut = p2Reg;

  for (genvar i = 0; i < NIB_W; i++) begin : g_p2Pin
    assign p2PinOe[i]  = dirCfg[i];
    assign coreP2In[i] = (psenN && !dirCfg[i]) ? p2PinIn[i] : 1'b1;
  end
endmodule

// File: rtl/ioRestore.sv
module ioRestore
  import ioRestorePkg::*;
#(
  parameter int BUS_W = 8,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] coreBusOut,
  output logic [BUS_W-1:0] coreBusIn,
  input  logic             aleIn,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             psenN,
  input  logic             pcHigh,
  input  logic [NIB_W-1:0] coreP2Out,
  output logic [NIB_W-1:0] coreP2In,
  input  logic [NIB_W-1:0] dirCfg,
  input  logic [BUS_W-1:0] dbPinIn,
  output logic [BUS_W-1:0] dbPinOut,
  output logic             dbPinOe,
  input  logic [NIB_W-1:0] p2PinIn,
  output logic [NIB_W-1:0] p2PinOut,
  output logic [NIB_W-1:0] p2PinOe,
  input  logic             eaPin,
  output logic [BUS_W-1:0] addrLow,
  output logic             romEnN,
  output logic             extPsenN
);
  ctlStrobes_t strobes;

  ioRestoreControl i_control (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .wrN(wrN), .psenN(psenN),
    .pcHigh(pcHigh), .eaPin(eaPin), .strobes(strobes),
    .romEnN(romEnN), .extPsenN(extPsenN)
  );

  ioRestoreDatapath #(.BUS_W(BUS_W), .NIB_W(NIB_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdN(rdN), .psenN(psenN),
    .coreBusOut(coreBusOut), .coreBusIn(coreBusIn),
    .coreP2Out(coreP2Out), .coreP2In(coreP2In), .dirCfg(dirCfg),
    .dbPinIn(dbPinIn), .dbPinOut(dbPinOut), .dbPinOe(dbPinOe),
    .p2PinIn(p2PinIn), .p2PinOut(p2PinOut), .p2PinOe(p2PinOe),
    .addrLow(addrLow)
  );
endmodule

// File: rtl/ioRestoreChecker.sv
module ioRestoreChecker #(
  parameter int BUS_W = 8,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] coreBusOut,
  input logic             aleIn,
  input logic             rdN,
  input logic             wrN,
  input logic             psenN,
  input logic [NIB_W-1:0] coreP2In,
  input logic [BUS_W-1:0] dbPinOut,
  input logic             dbPinOe,
  input logic [NIB_W-1:0] p2PinOut,
  input logic             romEnN,
  input logic             extPsenN
);
  AST_DB_TRAILING_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrN && !$past(wrN) && $past(rstN, 2)) |=> (dbPinOut == $past(coreBusOut, 2))); // R2
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrN && !$past(wrN)) |=> $stable(dbPinOut)); // R3
  AST_BUS_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    rdN |-> dbPinOe); // R4
  AST_P2_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(aleIn && !$past(aleIn)) |=> $stable(p2PinOut)); // R5
  AST_P2_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !psenN |-> (coreP2In == {NIB_W{1'b1}})); // R7
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    psenN |-> (extPsenN && romEnN)); // R8
  AST_SELECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!romEnN && !extPsenN)); // R9
  AST_SELECT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !psenN |-> $countones({romEnN, extPsenN}) == 1); // R9
endmodule

bind ioRestore ioRestoreChecker #(.BUS_W(BUS_W), .NIB_W(NIB_W)) u_ioRestoreChecker (
  .clk(clk), .rstN(rstN), .coreBusOut(coreBusOut), .aleIn(aleIn), .rdN(rdN),
  .wrN(wrN), .psenN(psenN), .coreP2In(coreP2In), .dbPinOut(dbPinOut),
  .dbPinOe(dbPinOe), .p2PinOut(p2PinOut), .romEnN(romEnN), .extPsenN(extPsenN)
);

// File: tb/test_ioRestore.sv
module test_ioRestore;
  localparam int BUS_W = 8;
  localparam int NIB_W = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [BUS_W-1:0] coreBusOut, coreBusIn, dbPinIn, dbPinOut, addrLow;
  logic aleIn, rdN, wrN, psenN, pcHigh, eaPin, dbPinOe, romEnN, extPsenN;
  logic [NIB_W-1:0] coreP2Out, coreP2In, dirCfg, p2PinIn, p2PinOut, p2PinOe;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ioRestore #(.BUS_W(BUS_W), .NIB_W(NIB_W)) i_ioRestore (
    .clk(clk), .rstN(rstN), .coreBusOut(coreBusOut), .coreBusIn(coreBusIn),
    .aleIn(aleIn), .rdN(rdN), .wrN(wrN), .psenN(psenN), .pcHigh(pcHigh),
    .coreP2Out(coreP2Out), .coreP2In(coreP2In), .dirCfg(dirCfg),
    .dbPinIn(dbPinIn), .dbPinOut(dbPinOut), .dbPinOe(dbPinOe),
    .p2PinIn(p2PinIn), .p2PinOut(p2PinOut), .p2PinOe(p2PinOe),
    .eaPin(eaPin), .addrLow(addrLow), .romEnN(romEnN), .extPsenN(extPsenN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [BUS_W-1:0] v);
    @(negedge clk); coreBusOut = v; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1; coreBusOut = ~v;  // bus changes as WR rises
    @(negedge clk);
    chk(dbPinOut == v, "R2 trailing-edge write", dbPinOut, v);
  endtask

  initial begin
    #(20 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; coreBusOut = '0; aleIn = 0; rdN = 1; wrN = 1; psenN = 1;
    pcHigh = 0; eaPin = 0; coreP2Out = '0; dirCfg = '0; dbPinIn = '0; p2PinIn = '0;
    repeat (3) @(negedge clk);
    chk(dbPinOut == 8'hFF, "R10 db reset", dbPinOut, 8'hFF);
    chk(p2PinOut == 4'hF, "R10 p2 reset", p2PinOut, 4'hF);
    rstN = 1'b1;
    @(negedge clk);

    // R2 writes with several patterns
    busWrite(8'h00); busWrite(8'hA5); busWrite(8'h3C); busWrite(8'hFF); busWrite(8'h81);

    // R3: bus activity without a WR strobe, including reads
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); coreBusOut = 8'(k * 37); rdN = k[0];
    end
    @(negedge clk); rdN = 1;
    @(negedge clk);
    chk(dbPinOut == 8'h81, "R3 no strobe hold", dbPinOut, 8'h81);

    // R4 direction
    dbPinIn = 8'h6E; rdN = 0; #1;
    chk(dbPinOe == 1'b0, "R4 read oe", dbPinOe, 0);
    chk(coreBusIn == 8'h6E, "R4 read data", coreBusIn, 8'h6E);
    rdN = 1; #1;
    chk(dbPinOe == 1'b1, "R4 idle oe", dbPinOe, 1);
    chk(coreBusIn == 8'hFF, "R4 idle data", coreBusIn, 8'hFF);

    // R1 address latch
    @(negedge clk); aleIn = 1; coreBusOut = 8'h47; #1;
    chk(addrLow == 8'h47, "R1 transparent", addrLow, 8'h47);
    @(negedge clk); aleIn = 0; coreBusOut = 8'hB2;
    @(negedge clk);
    chk(addrLow == 8'h47, "R1 held", addrLow, 8'h47);

    // R5 nibble capture on ALE rise, all values
    for (int n = 0; n < 16; n++) begin
      @(negedge clk); coreP2Out = 4'(n); aleIn = 1;
      @(negedge clk); coreP2Out = 4'(~n);
      @(negedge clk); aleIn = 0;
      @(negedge clk); coreP2Out = 4'(n + 5);
      @(negedge clk);
      chk(p2PinOut == 4'(n), "R5 capture and hold", p2PinOut, n);
    end

    // R6 R7 exhaustive gating sweep
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        for (int s = 0; s < 2; s++) begin
          logic [NIB_W-1:0] expIn;
          dirCfg = 4'(c); p2PinIn = 4'(p); psenN = s[0]; #1;
          expIn = s[0] ? (4'(p) | 4'(c)) : 4'hF;
          chk(coreP2In == expIn, "R7 input gating", coreP2In, expIn);
          chk(p2PinOe == 4'(c), "R6 per-pin direction", p2PinOe, c);
        end
      end
    end
    psenN = 1;

    // R8 R9 select logic
    for (int m = 0; m < 8; m++) begin
      bit act, off;
      psenN = m[0]; pcHigh = m[1]; eaPin = m[2]; #1;
      act = !m[0]; off = m[1] || m[2];
      chk(extPsenN == !(act && off), "R8 external strobe", extPsenN, !(act && off));
      chk(romEnN == !(act && !off), "R9 rom enable", romEnN, !(act && !off));
    end
    psenN = 1; pcHigh = 0; eaPin = 0;

    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule